// File: doc/BRIEF.md
# T1/E1 Frame Event Status Generator

This block turns per-frame start strobes from a T1/E1 line interface into the periodic framing events a host needs. Each strobe marks a 125 µs frame on the receive or transmit side. From these strobes the block derives align-frame, multiframe and CRC4-multiframe events. Each event appears as a one-cycle pulse and also sets a sticky bit in an 8-bit status byte. The host clears a bit by writing a 1 to it.

The period of each event comes from counting strobes. Align frames use every second frame. A multiframe is 16 frames in E1, 12 frames for T1 D4 framing and 24 frames for T1 ESF framing. The CRC4 multiframe event runs on its own 16-frame counter. That counter free-runs on an arbitrary phase while CRC4 lock is absent, and it realigns when lock is gained. Framing itself, CRC checking and extraction of spare bits are handled elsewhere.

Top module: `frm_evt_status`

## Requirements
- R1: After reset every status bit and every event pulse is 0.
- R2: In E1 mode the receive align event (pulse and status bit 0) fires on every second receive frame strobe. The first one comes on the 2nd strobe after reset or after a mode change.
- R3: In E1 mode the transmit align event (pulse and status bit 3) fires on every second transmit frame strobe, with the same phase rule as R2.
- R4: In E1 mode the receive multiframe event (bit 2) and the transmit multiframe event (bit 4) fire on every 16th strobe of their own side, whatever the CRC4 lock state.
- R5: In T1 mode the multiframe events (bits 2 and 4) fire every 12 strobes when cfg_esf is 0 (D4) and every 24 strobes when cfg_esf is 1 (ESF).
- R6: In T1 mode the align events and the CRC4 event (bits 0, 1, 3) never fire.
- R7: In E1 mode the CRC4 multiframe event (bit 1) fires on every 16th receive strobe. While crc4_locked is low this counter free-runs. A rising edge of crc4_locked restarts it, so the next event comes on the 16th receive strobe after the edge. A falling edge has no effect.
- R8: Writing with host_wr high clears each status bit whose host_wdata bit is 1 and leaves the other bits unchanged. An event in the same cycle as a clear leaves its bit set.
- R9: Any change of cfg_e1 or cfg_esf restarts all period counters, so every event next fires one full period of strobes later. Status bits already set stay set.
- R10: Status bits 7 to 5 always read 0.
- R11: An event pulse is high for exactly the one cycle after the edge that samples its strobe. The matching status bit is set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_stb | input | 1 | One-cycle strobe at each receive frame start |
| tx_frame_stb | input | 1 | One-cycle strobe at each transmit frame start |
| crc4_locked | input | 1 | Receive CRC4 multiframe lock flag |
| cfg_e1 | input | 1 | 1 selects E1, 0 selects T1 |
| cfg_esf | input | 1 | T1 only: 1 selects ESF, 0 selects D4 |
| host_wr | input | 1 | Host write strobe for the status byte |
| host_wdata | input | 8 | Write data; a 1 clears the matching status bit |
| evt_pulse | output | 5 | Event pulses: 0 rx align, 1 CRC4 MF, 2 rx MF, 3 tx align, 4 tx MF |
| status | output | 8 | Sticky status byte, same bit positions as evt_pulse |

## Verification
The following hold on every cycle and are checked continuously:
- Each period counter stays below its modulus.
- No align or CRC4 pulse appears outside E1 mode.
- A receive multiframe pulse always follows a receive strobe.
- Every pulse is reflected in its status bit.
- A status bit only falls after a write of 1 to it.

The following can only be shown by the bench's sweeps, which compare against strobe counts kept in the bench:
- The actual periods (2, 12, 16, 24).
- The phase after reset, after a mode change and after a lock edge.
- The outcome when a clear and an event meet in the same cycle.

// File: rtl/frm_evt_pkg.sv
package frm_evt_pkg;
    localparam int CNT_W      = 5;
    localparam int STAT_W     = 8;
    localparam int N_EVT      = 5;
    localparam int ALIGN_MOD  = 2;
    localparam int E1_MF_MOD  = 16;
    localparam int D4_MF_MOD  = 12;
    localparam int ESF_MF_MOD = 24;
    localparam int CRC_MF_MOD = 16;

    // event bit positions inside evt_pulse and status
    localparam int EV_RX_ALIGN = 0;
    localparam int EV_CRC_MF   = 1;
    localparam int EV_RX_MF    = 2;
    localparam int EV_TX_ALIGN = 3;
    localparam int EV_TX_MF    = 4;

    function automatic logic [CNT_W-1:0] mf_modulus(input logic e1, input logic esf);
        if (e1)
            return CNT_W'(E1_MF_MOD);
        else if (esf)
            return CNT_W'(ESF_MF_MOD);
        else
            return CNT_W'(D4_MF_MOD);
    endfunction
endpackage

// File: rtl/frm_period_cnt.sv
module frm_period_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] modulus,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            hit = (st_q.cnt == modulus - W'(1));
            st_d.cnt = hit ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: period counter never exceeds its selected modulus
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (st_q.cnt < modulus));
endmodule

// File: rtl/frm_status_reg.sv
module frm_status_reg #(
    parameter int NE = 5,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] set,
    input  logic          wr,
    input  logic [SW-1:0] wdata,
    output logic [NE-1:0] evt,
    output logic [SW-1:0] status
);
    typedef struct packed {
        logic [NE-1:0] evt;
        logic [NE-1:0] sticky;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NE-1:0] clr_mask;

    always_comb begin
        clr_mask     = wr ? wdata[NE-1:0] : '0;
        st_d.evt     = set;
        st_d.sticky  = (st_q.sticky & ~clr_mask) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt    = st_q.evt;
    assign status = {{(SW-NE){1'b0}}, st_q.sticky};

    // R11: every pulse shows in its status bit in the same cycle
    assert_pulse_in_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~status[NE-1:0]) == '0);

    // R8: a status bit only falls after the host wrote a 1 to it
    assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[NE-1:0]) & ~status[NE-1:0]
            & ~($past(wr) ? $past(wdata[NE-1:0]) : '0)) == '0);
endmodule

// File: rtl/frm_evt_status.sv
module frm_evt_status
    import frm_evt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_frame_stb,
    input  logic             tx_frame_stb,
    input  logic             crc4_locked,
    input  logic             cfg_e1,
    input  logic             cfg_esf,
    input  logic             host_wr,
    input  logic [SW-1:0]    host_wdata,
    output logic [N_EVT-1:0] evt_pulse,
    output logic [SW-1:0]    status
);
    localparam int NE = N_EVT;

    typedef struct packed {
        logic e1;
        logic esf;
        logic lock;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          mode_chg;
    logic          lock_rise;
    logic [1:0]    stb;
    logic [CW-1:0] mf_mod;
    logic [NE-1:0] hit;

    always_comb begin
        ctl_d.e1   = cfg_e1;
        ctl_d.esf  = cfg_esf;
        ctl_d.lock = crc4_locked;
        mode_chg   = (ctl_q.e1 != cfg_e1) || (ctl_q.esf != cfg_esf);
        lock_rise  = crc4_locked && !ctl_q.lock;
        stb        = {tx_frame_stb, rx_frame_stb};
        mf_mod     = mf_modulus(cfg_e1, cfg_esf);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int AI = (s == 0) ? EV_RX_ALIGN : EV_TX_ALIGN;
        localparam int MI = (s == 0) ? EV_RX_MF    : EV_TX_MF;

        frm_period_cnt #(.W(CW)) u_align (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mode_chg),
            .adv     (stb[s] & cfg_e1),
            .modulus (CW'(ALIGN_MOD)),
            .hit     (hit[AI])
        );

        frm_period_cnt #(.W(CW)) u_mf (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mode_chg),
            .adv     (stb[s]),
            .modulus (mf_mod),
            .hit     (hit[MI])
        );
    end

    frm_period_cnt #(.W(CW)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg | lock_rise),
        .adv     (rx_frame_stb & cfg_e1),
        .modulus (CW'(CRC_MF_MOD)),
        .hit     (hit[EV_CRC_MF])
    );

    frm_status_reg #(.NE(NE), .SW(SW)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hit),
        .wr     (host_wr),
        .wdata  (host_wdata),
        .evt    (evt_pulse),
        .status (status)
    );

    // R6: align and CRC4 pulses only follow a cycle spent in E1 mode
    assert_t1_no_e1_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[EV_RX_ALIGN] | evt_pulse[EV_CRC_MF] | evt_pulse[EV_TX_ALIGN])
            |-> $past(cfg_e1));

    // R4: a receive multiframe pulse needs a receive strobe one cycle earlier
    assert_rx_mf_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[EV_RX_MF] |-> $past(rx_frame_stb));
endmodule

// File: tb/sim_frm_evt_status.sv
module sim_frm_evt_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b0, tx = 1'b0, lock = 1'b0, e1 = 1'b0, esf = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [4:0] evt_pulse;
    logic [7:0] status;

    int   n_chk = 0, n_fail = 0;
    int   rx_n = 0, tx_n = 0, crc_n = 0;
    logic [4:0] exp_st = '0;
    bit   done = 0;

    always #5 clk = ~clk;

    frm_evt_status u0 (
        .clk(clk), .rst_n(rst_n), .rx_frame_stb(rx), .tx_frame_stb(tx),
        .crc4_locked(lock), .cfg_e1(e1), .cfg_esf(esf), .host_wr(host_wr),
        .host_wdata(host_wdata), .evt_pulse(evt_pulse), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic int mf_period();
        if (e1) return 16;
        return esf ? 24 : 12;
    endfunction

    // one cycle of stimulus, then checks of pulses and status
    task automatic step(input logic rs, input logic ts, input logic wr,
                        input logic [7:0] wd, input string tag);
        logic [4:0] ee;
        ee = '0;
        @(negedge clk);
        rx = rs; tx = ts; host_wr = wr; host_wdata = wd;
        if (rs) rx_n++;
        if (ts) tx_n++;
        if (rs && e1) crc_n++;
        if (e1) begin
            ee[0] = rs && (rx_n % 2 == 0);
            ee[1] = rs && (crc_n % 16 == 0);
            ee[3] = ts && (tx_n % 2 == 0);
        end
        ee[2] = rs && (rx_n % mf_period() == 0);
        ee[4] = ts && (tx_n % mf_period() == 0);
        exp_st = (exp_st & ~(wr ? wd[4:0] : 5'b0)) | ee;
        @(posedge clk);
        #1 rx = 0; tx = 0; host_wr = 0; host_wdata = '0;
        @(negedge clk);
        check({tag, " pulse (R11)"}, {3'b0, evt_pulse}, {3'b0, ee});
        check({tag, " status (R8/R10)"}, status, {3'b0, exp_st});
    endtask

    task automatic set_mode(input logic m_e1, input logic m_esf);
        @(negedge clk);
        e1 = m_e1; esf = m_esf;
        rx_n = 0; tx_n = 0; crc_n = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic wr;
            logic [7:0] wd;
            wr = (k % 5 == 4) || (k % 7 == 3);
            wd = (k % 5 == 4) ? 8'hFF : 8'h55;
            step(1'b1, (k % 3 != 0), wr, wd, tag);
            if (k % 11 == 10) step(1'b0, 1'b0, 1'b0, 8'h00, {tag, " idle"});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", status, 8'h00);
        check("R1 pulse", {3'b0, evt_pulse}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // T1 D4 from reset (mode equals reset state)
        sweep(60, "R5 D4");
        step(1'b0, 1'b0, 1'b1, 8'hFF, "R8 clear all");
        set_mode(1'b0, 1'b1);
        sweep(80, "R5 ESF");
        // R9: switch with counters mid-period, status kept
        set_mode(1'b1, 1'b0);
        sweep(70, "R2/R3/R4 E1");
        set_mode(1'b0, 1'b0);
        sweep(30, "R9/R6 back to D4");
        set_mode(1'b1, 1'b0);

        // R7: free-running CRC4 then realign on lock rise
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, 8'h00, "R7 free run");
        @(negedge clk); lock = 1'b1; crc_n = 0;
        @(negedge clk);
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 1'b0, 8'h00, "R7 after lock rise");
        @(negedge clk); lock = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 16; k++) step(1'b1, 1'b1, 1'b0, 8'h00, "R7 lock fall no effect");

        // R8: write of zeros leaves status unchanged
        step(1'b0, 1'b0, 1'b1, 8'h00, "R8 write zeros");
        // R8: clear and event together keeps the bit (rx_n odd -> next strobe is align)
        if (rx_n % 2 == 0) step(1'b1, 1'b0, 1'b0, 8'h00, "R8 phase");
        step(1'b1, 1'b0, 1'b1, 8'h01, "R8 clear vs event");
        step(1'b0, 1'b0, 1'b1, 8'hE0, "R10 upper write");
        step(1'b0, 1'b0, 1'b1, 8'hFF, "R8 final clear");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule